// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address that a synchronous SRAM core uses during a four-beat burst. A burst begins when one of two address strobes is sampled high on a rising clock edge. The processor-side strobe captures the processor address bus, and the cache-side strobe captures the cache-controller address bus. The captured value is the base of the burst.

After the load, the lowest `BEAT_W` address bits come from an internal beat counter. The counter moves forward only on cycles where the advance input is high. The upper address bits keep the base value for the whole burst.

The order-select input picks how the beat count is combined with the base low bits:

- **Linear order:** the base low bits plus the count, modulo four. The address wraps inside the aligned four-word block.
- **Interleaved order:** the base low bits XOR the count.

Order-select is a static configuration pin. Board logic should pull it high when interleaved order is the default. Arbitration between the two masters is left to the system. When both strobes arrive together, the block applies a fixed priority.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after reset is released with no strobe, `core_addr` is 0.
- R2: A high `proc_stb` at a rising edge loads `proc_addr`. `core_addr` equals `proc_addr` after that edge, and the beat count restarts at 0.
- R3: A high `ctrl_stb` with `proc_stb` low at a rising edge loads `ctrl_addr` in the same way.
- R4: When both strobes are high at the same edge, `proc_addr` is loaded and `ctrl_addr` is ignored.
- R5: A strobe sampled together with `adv` loads the new base, and that edge does not step the count.
- R6: With `order_sel` = 0 (linear), each edge with `adv` high and no strobe makes `core_addr[1:0]` equal to (base low bits + count) mod 4.
- R7: With `order_sel` = 1 (interleaved), `core_addr[1:0]` equals base low bits XOR count.
- R8: An edge with no strobe and no `adv` leaves `core_addr` unchanged.
- R9: The fifth address of a burst (after four advances) equals the first, so the burst never leaves its four-word block.
- R10: `core_addr[ADDR_W-1:2]` stays equal to the loaded base for every advance of a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_stb | input | 1 | Processor address strobe, highest priority |
| ctrl_stb | input | 1 | Cache-controller address strobe |
| adv | input | 1 | Step to the next beat |
| order_sel | input | 1 | 0 = linear wrap, 1 = interleaved XOR |
| proc_addr | input | ADDR_W | Processor address bus |
| ctrl_addr | input | ADDR_W | Cache-controller address bus |
| core_addr | output | ADDR_W | Address sent to the memory core |

## Verification
A strobe or advance sampled at a rising edge shows up on `core_addr` just after that same edge. There is exactly one register stage between the inputs and the output. `order_sel` acts combinationally on the stored base and count.

The bench sets inputs on a falling edge and lets exactly one rising edge pass. It compares `core_addr` at the next falling edge, before any input changes. This way each check sees the result of exactly one sampled stimulus.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PROC = 2'd1,
    SRC_CTRL = 2'd2
  } load_src_e;
endpackage

// File: rtl/strobe_select.sv
module strobe_select #(
  parameter int ADDR_W = 18
) (
  input  logic              proc_stb,
  input  logic              ctrl_stb,
  input  logic [ADDR_W-1:0] proc_addr,
  input  logic [ADDR_W-1:0] ctrl_addr,
  output logic              load,
  output logic [ADDR_W-1:0] load_addr
);
  import burst_pkg::*;

  load_src_e src;

  always_comb begin
    if (proc_stb)      src = SRC_PROC;
    else if (ctrl_stb) src = SRC_CTRL;
    else               src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_PROC: load_addr = proc_addr;
      SRC_CTRL: load_addr = ctrl_addr;
      default:  load_addr = '0;
    endcase
    load = (src != SRC_NONE);
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [BEAT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + BEAT_W'(1);
  end
endmodule

// File: rtl/base_reg.sv
module base_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/beat_order.sv
module beat_order #(
  parameter int BEAT_W = 2
) (
  input  logic              order_sel,
  input  logic [BEAT_W-1:0] base_lo,
  input  logic [BEAT_W-1:0] cnt,
  output logic [BEAT_W-1:0] beat_lo
);
  import burst_pkg::*;

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] xor_lo;

  assign lin_lo = base_lo + cnt;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_xor
    assign xor_lo[i] = base_lo[i] ^ cnt[i];
  end

  always_comb begin
    if (burst_order_e'(order_sel) == ORD_XOR) beat_lo = xor_lo;
    else                                      beat_lo = lin_lo;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_stb,
  input  logic              ctrl_stb,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] proc_addr,
  input  logic [ADDR_W-1:0] ctrl_addr,
  output logic [ADDR_W-1:0] core_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] load_addr;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt;
  logic [BEAT_W-1:0] beat_lo;

  strobe_select #(.ADDR_W(ADDR_W)) sel_i (
    .proc_stb (proc_stb),
    .ctrl_stb (ctrl_stb),
    .proc_addr(proc_addr),
    .ctrl_addr(ctrl_addr),
    .load     (load),
    .load_addr(load_addr)
  );

  base_reg #(.ADDR_W(ADDR_W)) base_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .d    (load_addr),
    .q    (base_q)
  );

  beat_counter #(.BEAT_W(BEAT_W)) cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(load),
    .step (adv),
    .cnt  (cnt)
  );

  beat_order #(.BEAT_W(BEAT_W)) ord_i (
    .order_sel(order_sel),
    .base_lo  (base_q[BEAT_W-1:0]),
    .cnt      (cnt),
    .beat_lo  (beat_lo)
  );

  assign core_addr = {base_q[ADDR_W-1 -: HI_W], beat_lo};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_stb,
  input logic              ctrl_stb,
  input logic              adv,
  input logic              order_sel,
  input logic [ADDR_W-1:0] proc_addr,
  input logic [ADDR_W-1:0] ctrl_addr,
  input logic [ADDR_W-1:0] core_addr
);
  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (core_addr == '0); // R1
  end

  AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    proc_stb |=> core_addr == $past(proc_addr)); // R4

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_stb && !proc_stb) |=> core_addr == $past(ctrl_addr)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb && !ctrl_stb && !adv) |=>
      (!$stable(order_sel) || $stable(core_addr))); // R8

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb && !ctrl_stb) |=>
      $stable(core_addr[ADDR_W-1:BEAT_W])); // R10

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !proc_stb && !ctrl_stb && !order_sel) |=>
      (order_sel || core_addr[BEAT_W-1:0] ==
        BEAT_W'($past(core_addr[BEAT_W-1:0]) + BEAT_W'(1)))); // R6
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .proc_stb (proc_stb),
  .ctrl_stb (ctrl_stb),
  .adv      (adv),
  .order_sel(order_sel),
  .proc_addr(proc_addr),
  .ctrl_addr(ctrl_addr),
  .core_addr(core_addr)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int ADDR_W = 18;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              proc_stb = 1'b0;
  logic              ctrl_stb = 1'b0;
  logic              adv = 1'b0;
  logic              order_sel = 1'b0;
  logic [ADDR_W-1:0] proc_addr = '0;
  logic [ADDR_W-1:0] ctrl_addr = '0;
  logic [ADDR_W-1:0] core_addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .proc_stb(proc_stb), .ctrl_stb(ctrl_stb),
    .adv(adv), .order_sel(order_sel), .proc_addr(proc_addr),
    .ctrl_addr(ctrl_addr), .core_addr(core_addr)
  );

  task automatic check(input string req, input logic [ADDR_W-1:0] got,
                       input logic [ADDR_W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic c, input logic a);
    proc_stb = p;
    ctrl_stb = c;
    adv = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] base;
    logic [1:0] lo;
    @(negedge clk);
    check("R1 in reset", core_addr, '0);
    rst_n = 1'b1;
    cyc(0, 0, 0);
    check("R1 after reset", core_addr, '0);

    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 4; b++) begin
        for (int s = 0; s < 2; s++) begin
          order_sel = m[0];
          base = ADDR_W'((b * 37 + m * 5001 + s * 911) * 4 + b);
          if (s == 0) begin
            proc_addr = base;
            ctrl_addr = ~base;
            cyc(1, 0, 0);
            check("R2 proc load", core_addr, base);
          end else begin
            ctrl_addr = base;
            proc_addr = ~base;
            cyc(0, 1, 0);
            check("R3 ctrl load", core_addr, base);
          end
          for (int k = 1; k <= 5; k++) begin
            cyc(0, 0, 1);
            if (m == 0) lo = 2'((b + k) % 4);
            else        lo = 2'(b ^ (k % 4));
            if (k == 4)
              check("R9 wrap to first", core_addr, base);
            else if (m == 0)
              check("R6 linear beat", core_addr, {base[ADDR_W-1:2], lo});
            else
              check("R7 interleaved beat", core_addr, {base[ADDR_W-1:2], lo});
            check("R10 upper fixed", {core_addr[ADDR_W-1:2], 2'b00},
                  {base[ADDR_W-1:2], 2'b00});
            if (k == 2) begin
              cyc(0, 0, 0);
              check("R8 idle hold", core_addr, {base[ADDR_W-1:2], lo});
            end
          end
        end
      end
    end

    order_sel = 1'b0;
    proc_addr = 18'h2A5C1;
    ctrl_addr = 18'h1B3F2;
    cyc(1, 1, 0);
    check("R4 proc priority", core_addr, 18'h2A5C1);
    cyc(0, 0, 1);
    cyc(0, 0, 1);
    proc_addr = 18'h0F0F2;
    cyc(1, 0, 1);
    check("R5 strobe beats adv", core_addr, 18'h0F0F2);
    ctrl_addr = 18'h33333;
    cyc(0, 1, 1);
    check("R5 ctrl strobe beats adv", core_addr, 18'h33333);
    cyc(0, 0, 1);
    check("R6 linear after reload", core_addr, 18'h33330);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule